// File: doc/BRIEF.md
# Asynchronous Host Word-Memory Bridge

This block connects a host processor to an internal dual-ported word memory over a non-multiplexed asynchronous bus. The host presents a 12-bit word address, a 16-bit data word and three active-low strobes: chip select, write strobe and output strobe. The bridge passes the strobes through two-flop synchronizers into the controller clock domain. It then performs one memory cycle per access and reports completion on an open-drain, active-low ready line. Accesses always move a whole 16-bit word. Address bit 0 picks the even or odd word, and there are no byte lanes.

The ready line is modelled as a drive-enable and a drive-value pair. While the access is pending, ready is driven low. When ready is withdrawn, it is first driven high for a programmable number of controller cycles and then floated to the weak pull-up. A strap input selects between two ready modes. In the first, ready stays low until the host lifts its strobes. In the second, the ready pulse is aligned to rising edges of a host clock and lasts exactly one host clock period.

The memory is reached through a plain synchronous port that the host shares with an internal requester. The host always wins a collision. The bridge also carries an interrupt line that can only pull low.

Top module: `hmb_bridge`

## Requirements
- R1: While reset is held, and after it is released with all strobes inactive, `rdy_oe`, `data_oe`, `irq_pull_low` and `mem_req` are all 0.
- R2: A write (chip select low, write strobe low) stores the full 16-bit `bus_wdata` at the 12-bit word address `bus_addr`, where bit 0 selects the even or odd word. Ready is driven low (`rdy_oe`=1, `rdy_val`=0) on the third controller clock edge after the strobes fall, which is within the 4-cycle limit.
- R3: A read (chip select low, output strobe low) drives `data_oe`=1 and presents the stored word on `bus_rdata` when ready goes low. This happens on the fourth controller clock edge after the strobes fall, which is within the 8-cycle limit.
- R4: When `sync_rdy_mode`=0, ready stays driven low for as long as the strobes remain active.
- R5: Ready is withdrawn on the third edge after the strobes rise (when `sync_rdy_mode`=0) or after the host-clock pulse ends (when `sync_rdy_mode`=1). Once withdrawn, ready is driven high (`rdy_oe`=1, `rdy_val`=1) for exactly `rdy_dly`+1 cycles, and then `rdy_oe` returns to 0.
- R6: When `sync_rdy_mode`=1, ready goes low on the third controller edge after a rising edge of `hclk` and stays low for exactly one `hclk` period.
- R7: No new access begins until the strobes of the previous access have been seen inactive. Strobes that are held low after a completed access produce no further ready pulse.
- R8: When the host and the internal requester want the memory in the same cycle, the host is served, `int_gnt` is 0 for exactly that one cycle, and both writes land.
- R9: `irq_pull_low` equals `int_irq` delayed by one clock. The line has only a pull-low enable and is never driven high.
- R10: A write strobe or output strobe with chip select high is ignored: no ready is driven and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| hclk | input | 1 | Host bus clock for aligned ready mode |
| sync_rdy_mode | input | 1 | 1: ready aligned to hclk; 0: ready held until strobes rise |
| rdy_dly | input | DLYW | Drive-high interval setting before ready floats |
| bus_addr | input | AW | Host word address |
| bus_wdata | input | DW | Host write data |
| bus_rdata | output | DW | Read data toward the host |
| data_oe | output | 1 | Read data drive enable |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| rdy_oe | output | 1 | Ready pin drive enable |
| rdy_val | output | 1 | Ready pin driven value (0 = ready) |
| int_irq | input | 1 | Internal interrupt request |
| irq_pull_low | output | 1 | Interrupt pin pull-low enable |
| int_req | input | 1 | Internal memory request |
| int_we | input | 1 | Internal write select |
| int_addr | input | AW | Internal word address |
| int_wdata | input | DW | Internal write data |
| int_gnt | output | 1 | Internal request served this cycle |
| mem_req | output | 1 | Memory port request |
| mem_we | output | 1 | Memory port write select |
| mem_addr | output | AW | Memory port word address |
| mem_wdata | output | DW | Memory port write data |
| mem_rdata | input | DW | Memory port read data, valid one cycle after a request |

## Verification
The bench builds the bridge with its default widths: a 12-bit address, a 16-bit word and a 2-bit release setting. With these widths, every one of the four drive-high intervals is exercised across the vector table. Its memory model keeps only 64 words, so the all-ones address aliases onto word 63. That alias still distinguishes the even and odd neighbours that the tests use. The host clock runs at one eighth of the controller rate, which makes the one-period ready pulse of the aligned mode eight controller cycles long and easy to measure.

// File: rtl/hmb_pkg.sv
package hmb_pkg;

    localparam int HMB_AW   = 12;
    localparam int HMB_DW   = 16;
    localparam int HMB_DLYW = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RDWAIT,
        ST_ALIGN,
        ST_ACTIVE,
        ST_RELEASE
    } hmb_state_e;

    // Strobes after inversion: 1 means asserted
    typedef struct packed {
        logic cs;
        logic we;
        logic oe;
    } strobe_t;

    function automatic logic strobe_busy(strobe_t s);
        return s.cs && (s.we || s.oe);
    endfunction

endpackage

// File: rtl/hmb_sync.sv
module hmb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= '0;
            else     chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hmb_arbiter.sv
module hmb_arbiter #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          host_req,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic          int_req,
    input  logic          int_we,
    input  logic [AW-1:0] int_addr,
    input  logic [DW-1:0] int_wdata,
    output logic          int_gnt,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    // Host has fixed priority; the internal side simply retries next cycle
    always_comb begin
        int_gnt = int_req && !host_req;
        mem_req = host_req || int_req;
        if (host_req) begin
            mem_we    = host_we;
            mem_addr  = host_addr;
            mem_wdata = host_wdata;
        end else begin
            mem_we    = int_we && int_req;
            mem_addr  = int_addr;
            mem_wdata = int_wdata;
        end
    end
endmodule

// File: rtl/hmb_release_timer.sv
module hmb_release_timer #(
    parameter int DLYW = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [DLYW-1:0] dly,
    output logic            done
);
    logic [DLYW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == dly);
endmodule

// File: rtl/hmb_bridge.sv
module hmb_bridge
    import hmb_pkg::*;
#(
    parameter int AW   = HMB_AW,
    parameter int DW   = HMB_DW,
    parameter int DLYW = HMB_DLYW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hclk,
    input  logic            sync_rdy_mode,
    input  logic [DLYW-1:0] rdy_dly,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            data_oe,
    input  logic            cs_n,
    input  logic            we_n,
    input  logic            oe_n,
    output logic            rdy_oe,
    output logic            rdy_val,
    input  logic            int_irq,
    output logic            irq_pull_low,
    input  logic            int_req,
    input  logic            int_we,
    input  logic [AW-1:0]   int_addr,
    input  logic [DW-1:0]   int_wdata,
    output logic            int_gnt,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata
);
    localparam int SW = $bits(strobe_t);

    strobe_t    strb;
    logic       busy;
    logic       armed;
    logic       start;
    logic       wr_q;
    logic       hclk_s, hclk_q, h_rise;
    logic       rel_done;
    logic       host_req;
    hmb_state_e state, state_nx;
    logic [DW-1:0] rdata_q;

    // Strobe and host clock synchronizers
    hmb_sync #(.W(SW), .STAGES(2)) u_strb_sync (
        .clk (clk),
        .rst (rst),
        .d   ({~cs_n, ~we_n, ~oe_n}),
        .q   (strb)
    );

    hmb_sync #(.W(1), .STAGES(2)) u_hclk_sync (
        .clk (clk),
        .rst (rst),
        .d   (hclk),
        .q   (hclk_s)
    );

    always_ff @(posedge clk) begin
        if (rst) hclk_q <= 1'b0;
        else     hclk_q <= hclk_s;
    end
    assign h_rise = hclk_s && !hclk_q;

    assign busy  = strobe_busy(strb);
    assign start = (state == ST_IDLE) && armed && busy;

    // Re-arm only after the strobes were seen inactive
    always_ff @(posedge clk) begin
        if (rst)        armed <= 1'b0;
        else if (start) armed <= 1'b0;
        else if (!busy) armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)        wr_q <= 1'b0;
        else if (start) wr_q <= strb.we;
    end

    assign host_req = start;

    hmb_arbiter #(.AW(AW), .DW(DW)) u_arb (
        .host_req   (host_req),
        .host_we    (strb.we),
        .host_addr  (bus_addr),
        .host_wdata (bus_wdata),
        .int_req    (int_req),
        .int_we     (int_we),
        .int_addr   (int_addr),
        .int_wdata  (int_wdata),
        .int_gnt    (int_gnt),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    hmb_release_timer #(.DLYW(DLYW)) u_rel (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_RELEASE),
        .dly  (rdy_dly),
        .done (rel_done)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (!strb.we)          state_nx = ST_RDWAIT;
                    else if (sync_rdy_mode) state_nx = ST_ALIGN;
                    else                    state_nx = ST_ACTIVE;
                end
            end
            ST_RDWAIT:  state_nx = sync_rdy_mode ? ST_ALIGN : ST_ACTIVE;
            ST_ALIGN:   if (h_rise) state_nx = ST_ACTIVE;
            ST_ACTIVE: begin
                if (sync_rdy_mode ? h_rise : !busy) state_nx = ST_RELEASE;
            end
            ST_RELEASE: if (rel_done) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst)                     rdata_q <= '0;
        else if (state == ST_RDWAIT) rdata_q <= mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_pull_low <= 1'b0;
        else     irq_pull_low <= int_irq;
    end

    assign bus_rdata = rdata_q;
    assign data_oe   = !wr_q && ((state == ST_ALIGN) || (state == ST_ACTIVE));
    assign rdy_oe    = (state == ST_ACTIVE) || (state == ST_RELEASE);
    assign rdy_val   = (state != ST_ACTIVE);
endmodule

// File: rtl/hmb_bridge_chk.sv
module hmb_bridge_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          rdy_oe,
    input logic          rdy_val,
    input logic          data_oe,
    input logic          int_irq,
    input logic          irq_pull_low,
    input logic          int_gnt,
    input logic          int_we,
    input logic [AW-1:0] int_addr,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr
);
    // R4: ready is only ever low while actively driven
    a_r4_low_is_driven: assert property (@(posedge clk) disable iff (rst)
        !rdy_val |-> rdy_oe);

    // R5: a low ready is never floated directly, it passes through drive-high
    a_r5_no_float_from_low: assert property (@(posedge clk) disable iff (rst)
        (rdy_oe && !rdy_val) |=> rdy_oe);

    // R7: a release interval is never followed at once by a new low
    a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (rdy_oe && rdy_val) |=> !(rdy_oe && !rdy_val));

    // R3: read data is not driven during the release interval
    a_r3_no_data_in_release: assert property (@(posedge clk) disable iff (rst)
        (rdy_oe && rdy_val) |-> !data_oe);

    // R8: a granted internal request owns the memory port
    a_r8_internal_routed: assert property (@(posedge clk) disable iff (rst)
        int_gnt |-> (mem_we == int_we && mem_addr == int_addr));

    // R9: interrupt pull-low follows the request one clock later
    a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq_pull_low == $past(int_irq)));
endmodule

bind hmb_bridge hmb_bridge_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rdy_oe       (rdy_oe),
    .rdy_val      (rdy_val),
    .data_oe      (data_oe),
    .int_irq      (int_irq),
    .irq_pull_low (irq_pull_low),
    .int_gnt      (int_gnt),
    .int_we       (int_we),
    .int_addr     (int_addr),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr)
);

// File: tb/tb_hmb_bridge.sv
module tb_hmb_bridge;
    localparam int AW   = 12;
    localparam int DW   = 16;
    localparam int DLYW = 2;
    localparam int NV   = 8;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [1:0]    dly;
    } vec_t;

    // writes store d; reads expect d
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h000, 16'hA5A5, 2'd0},
        '{1'b1, 12'h001, 16'h5A5A, 2'd1},
        '{1'b0, 12'h000, 16'hA5A5, 2'd2},
        '{1'b0, 12'h001, 16'h5A5A, 2'd3},
        '{1'b1, 12'hFFF, 16'hFFFF, 2'd3},
        '{1'b1, 12'h012, 16'h0000, 2'd1},
        '{1'b0, 12'hFFF, 16'hFFFF, 2'd0},
        '{1'b0, 12'h012, 16'h0000, 2'd2}
    };

    logic clk = 1'b0, rst = 1'b1, hclk = 1'b0;
    logic sync_rdy_mode = 1'b0;
    logic [DLYW-1:0] rdy_dly = '0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0, bus_rdata;
    logic data_oe, rdy_oe, rdy_val, irq_pull_low, int_gnt;
    logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic int_irq = 1'b0, int_req = 1'b0, int_we = 1'b0;
    logic [AW-1:0] int_addr = '0;
    logic [DW-1:0] int_wdata = '0;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    int n_chk = 0, n_err = 0, stall_cnt = 0;
    bit finished = 0;
    time t_h = 0;

    always #4 clk = ~clk;
    initial begin
        #1;
        forever begin hclk = 1'b1; #32; hclk = 1'b0; #32; end
    end
    always @(posedge hclk) t_h = $time;

    // synchronous memory model, 64 words
    logic [DW-1:0] bmem [64];
    always_ff @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) bmem[mem_addr[5:0]] <= mem_wdata;
            mem_rdata <= bmem[mem_addr[5:0]];
        end
    end

    always @(posedge clk) if (!rst && int_req && !int_gnt) stall_cnt++;

    hmb_bridge #(.AW(AW), .DW(DW), .DLYW(DLYW)) dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [1:0] dly);
        int n, h;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; rdy_dly = dly;
        cs_n = 1'b0; we_n = !wr; oe_n = wr;
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!(rdy_oe && !rdy_val) && n < 20);
        if (wr) chk(n == 3, "R2 write ready latency", n, 3);
        else begin
            chk(n == 4, "R3 read ready latency", n, 4);
            chk(data_oe == 1'b1, "R3 data drive", data_oe, 1);
            chk(bus_rdata == d, "R3 read data", bus_rdata, d);
        end
        repeat (5) begin @(posedge clk); #1; end
        chk(rdy_oe && !rdy_val, "R4 ready held while strobes low", {rdy_oe, rdy_val}, 2);
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!(rdy_oe && rdy_val) && n < 20);
        chk(n == 3, "R5 release start", n, 3);
        h = 0;
        while (rdy_oe && rdy_val && h < 20) begin h++; @(posedge clk); #1; end
        chk(h == int'(dly) + 1, "R5 drive-high length", h, int'(dly) + 1);
        chk(!rdy_oe, "R5 ready floated", rdy_oe, 0);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!rdy_oe && !data_oe && !irq_pull_low && !mem_req, "R1 state during reset",
            {rdy_oe, data_oe, irq_pull_low, mem_req}, 0);
        @(negedge clk); rst = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk(!rdy_oe && !data_oe && !irq_pull_low && !mem_req, "R1 state after reset",
            {rdy_oe, data_oe, irq_pull_low, mem_req}, 0);

        // vector table: R2..R5
        for (int i = 0; i < NV; i++)
            access(VECS[i].wr, VECS[i].a, VECS[i].d, VECS[i].dly);

        // R10: chip select high, write strobe low
        begin
            bit seen = 0;
            @(negedge clk); bus_addr = 12'h000; bus_wdata = 16'h1111; we_n = 1'b0;
            repeat (10) begin @(posedge clk); #1; if (rdy_oe || mem_req) seen = 1; end
            @(negedge clk); we_n = 1'b1;
            chk(!seen, "R10 strobe without chip select ignored", seen, 0);
            repeat (3) @(posedge clk);
            access(1'b0, 12'h000, 16'hA5A5, 2'd0);   // R10: word unchanged
        end

        // R8: collision with the internal requester
        @(negedge clk);
        int_req = 1'b1; int_we = 1'b1; int_addr = 12'h020; int_wdata = 16'h1234;
        stall_cnt = 0;
        access(1'b1, 12'h021, 16'hBEEF, 2'd0);
        chk(stall_cnt == 1, "R8 internal stall cycles", stall_cnt, 1);
        @(negedge clk); int_req = 1'b0; int_we = 1'b0;
        access(1'b0, 12'h020, 16'h1234, 2'd0);       // R8 internal write landed
        access(1'b0, 12'h021, 16'hBEEF, 2'd0);       // R8 host write landed

        // R6 / R7: aligned ready mode
        begin
            int n, lc;
            bit again = 0;
            sync_rdy_mode = 1'b1;
            @(negedge clk);
            bus_addr = 12'h030; bus_wdata = 16'hC3C3; rdy_dly = 2'd0;
            cs_n = 1'b0; we_n = 1'b0;
            n = 0;
            do begin @(posedge clk); #1; n++; end while (!(rdy_oe && !rdy_val) && n < 40);
            chk(($time - t_h) > 16 && ($time - t_h) < 24, "R6 third edge after hclk rise",
                int'($time - t_h), 20);
            lc = 0;
            while (rdy_oe && !rdy_val && lc < 40) begin lc++; @(posedge clk); #1; end
            chk(lc == 8, "R6 pulse one hclk period", lc, 8);
            repeat (30) begin @(posedge clk); #1; if (rdy_oe && !rdy_val) again = 1; end
            chk(!again, "R7 no new access while strobes held", again, 0);
            @(negedge clk); cs_n = 1'b1; we_n = 1'b1;
            repeat (6) @(posedge clk);
            @(negedge clk); sync_rdy_mode = 1'b0;
            access(1'b0, 12'h030, 16'hC3C3, 2'd1);   // R6 aligned write stored once
        end

        // R9: interrupt
        @(negedge clk); int_irq = 1'b1;
        @(posedge clk); #1;
        chk(irq_pull_low == 1'b1, "R9 interrupt pulls low", irq_pull_low, 1);
        @(negedge clk); int_irq = 1'b0;
        @(posedge clk); #1;
        chk(irq_pull_low == 1'b0, "R9 interrupt released", irq_pull_low, 0);

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule